// File: doc/BRIEF.md
# Per-Port VLAN ID Filter Table

This block decides, for every received frame that carries a VLAN tag, whether the frame may continue into the layer-2 lookup stage or must be marked for drop. Each ingress port owns a small table of allowed 12-bit VLAN IDs and one filtering enable bit. A command interface adds or removes a VID on a port, and turns that port's filtering on or off. Turning filtering off also empties the port's table.

A lookup interface presents the ingress port number, a flag that says the frame is tagged, the 12-bit VID taken from the tag, and a flag that says the port runs in extended switch-tag mode. One clock later the block reports whether the VID is allowed on that port and whether the frame is to be dropped. It also reports how many header bytes the parser must skip: 4 for a normal tag and 8 for an extended tag. A tagged frame whose VID is not allowed is dropped only while filtering is enabled on its port. Otherwise it passes with no drop. The header still advances in both cases.

Top module: `vlan_vid_filter`

## Requirements
- R1: Each port holds up to SLOTS_PER_PORT (default 10) distinct allowed VIDs. An add command (cmd_op = 2'b00) of a VID not yet on the port is accepted with cmd_err = 0, and the VID becomes allowed.
- R2: An add of a VID already allowed on the port is accepted with cmd_err = 0 and uses no further slot. After such an add, the port still has room for the same number of new VIDs as before.
- R3: An add of a new VID to a port whose slots are all occupied is rejected with cmd_err = 1, and the port's table is left unchanged.
- R4: A lookup matches a stored VID only if all 12 bits are equal. A VID that differs in any single bit, including bit 11, does not match.
- R5: A tagged lookup whose VID is allowed on its port returns res_hit = 1 and res_drop = 0.
- R6: While filtering is enabled on a port (cmd_op = 2'b10), a tagged lookup whose VID is not allowed on that port returns res_hit = 0 and res_drop = 1, and res_skip still gives the tag length.
- R7: For a tagged lookup, res_skip is 4 when lk_ext = 0 and 8 when lk_ext = 1. An untagged lookup returns res_skip = 0, res_hit = 0 and res_drop = 0.
- R8: After reset, filtering is disabled on every port, and a tagged lookup with no allowed VID returns res_drop = 0.
- R9: A disable command (cmd_op = 2'b11) clears the port's filtering bit and removes all of its VIDs in the same cycle. An enable command leaves the stored VIDs untouched.
- R10: A remove command (cmd_op = 2'b01) of an allowed VID makes it no longer match and frees its slot for a later add. A remove of a VID that is not stored changes nothing and returns cmd_err = 0.
- R11: Ports are independent: a VID allowed on one port does not hit on another port, and enabling filtering on one port does not cause drops on another.
- R12: res_valid and the lookup result appear exactly one clock after lk_valid, and cmd_done appears one clock after cmd_valid. A command changes only lookups issued in later cycles, not a lookup issued in the same cycle.
- R13: A command naming a port number of NUM_PORTS or above returns cmd_err = 1 and has no effect. A lookup naming such a port returns res_hit = 0 and res_drop = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 add VID, 01 remove VID, 10 enable filtering, 11 disable filtering |
| cmd_port | input | PORT_W | Port the command acts on |
| cmd_vid | input | VID_W | VID for add or remove |
| cmd_done | output | 1 | Command acknowledged (one clock after cmd_valid) |
| cmd_err | output | 1 | Command rejected (table full or bad port), valid with cmd_done |
| lk_valid | input | 1 | Lookup request strobe |
| lk_port | input | PORT_W | Ingress port of the frame |
| lk_tagged | input | 1 | Frame carries a VLAN tag |
| lk_vid | input | VID_W | VID taken from the tag |
| lk_ext | input | 1 | Port uses the 8-byte extended tag |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | VID is allowed on the port |
| res_drop | output | 1 | Frame is to be dropped |
| res_skip | output | SKIP_W | Header bytes to skip |

## Verification
The bench builds the block with its defaults: three ports, ten slots per port and a 12-bit VID. A two-bit port number then leaves code 3 unused, so invalid-port commands and lookups can be tested. VIDs are drawn from a pool of fourteen values, so random add traffic fills a port's ten slots and reaches the table-full rejection. Disable commands are rare, so full ports persist long enough to hit the full case. Directed steps cover a command and a lookup in the same cycle, a single-bit VID difference in the top bit, and the reuse of a freed slot.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_REMOVE  = 2'b01,
        OP_ENABLE  = 2'b10,
        OP_DISABLE = 2'b11
    } vpf_op_e;
endpackage

// File: rtl/vpf_port_table.sv
module vpf_port_table #(
    parameter int SLOTS = 10,
    parameter int VID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_i,
    input  logic             rem_i,
    input  logic             clr_i,
    input  logic [VID_W-1:0] cmd_vid_i,
    input  logic [VID_W-1:0] lk_vid_i,
    output logic             present_o,
    output logic             full_o,
    output logic             lk_hit_o
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic [SLOTS-1:0]            used;
        logic [SLOTS-1:0][VID_W-1:0] vid;
    } tbl_t;

    tbl_t             st_d, st_q;
    logic [SLOTS-1:0] cmd_match;
    logic [SLOTS-1:0] lk_match;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            cmd_match[i] = st_q.used[i] && (st_q.vid[i] == cmd_vid_i);
            lk_match[i]  = st_q.used[i] && (st_q.vid[i] == lk_vid_i);
        end
    end

    assign present_o = |cmd_match;
    assign full_o    = &st_q.used;
    assign lk_hit_o  = |lk_match;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        // scan downward so the lowest free slot wins
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!st_q.used[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end

        st_d = st_q;
        if (clr_i) begin
            st_d.used = '0;
        end else if (add_i && !present_o && free_found) begin
            st_d.used[free_idx] = 1'b1;
            st_d.vid[free_idx]  = cmd_vid_i;
        end else if (rem_i) begin
            st_d.used = st_q.used & ~cmd_match;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vpf_ctrl.sv
module vpf_ctrl
    import vpf_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid_i,
    input  logic [1:0]           cmd_op_i,
    input  logic [PORT_W-1:0]    cmd_port_i,
    input  logic [NUM_PORTS-1:0] present_i,
    input  logic [NUM_PORTS-1:0] full_i,
    output logic [NUM_PORTS-1:0] add_o,
    output logic [NUM_PORTS-1:0] rem_o,
    output logic [NUM_PORTS-1:0] clr_o,
    output logic [NUM_PORTS-1:0] en_o,
    output logic                 done_o,
    output logic                 err_o
);
    typedef struct packed {
        logic [NUM_PORTS-1:0] en;
        logic                 done;
        logic                 err;
    } ctl_t;

    ctl_t                 st_d, st_q;
    vpf_op_e              op;
    logic                 port_ok;
    logic                 reject;
    logic [NUM_PORTS-1:0] sel;

    always_comb begin
        op      = vpf_op_e'(cmd_op_i);
        port_ok = (int'(cmd_port_i) < NUM_PORTS);
        reject  = 1'b0;
        st_d    = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            sel[p]   = cmd_valid_i && port_ok && (cmd_port_i == PORT_W'(p));
            add_o[p] = sel[p] && (op == OP_ADD);
            rem_o[p] = sel[p] && (op == OP_REMOVE);
            clr_o[p] = sel[p] && (op == OP_DISABLE);
            if (add_o[p] && !present_i[p] && full_i[p]) reject = 1'b1;
            if (sel[p] && (op == OP_ENABLE))  st_d.en[p] = 1'b1;
            if (sel[p] && (op == OP_DISABLE)) st_d.en[p] = 1'b0;
        end
        st_d.done = cmd_valid_i;
        st_d.err  = cmd_valid_i && (!port_ok || reject);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;
endmodule

// File: rtl/vpf_lookup.sv
module vpf_lookup #(
    parameter int NUM_PORTS  = 3,
    parameter int PORT_W     = 2,
    parameter int SHORT_SKIP = 4,
    parameter int LONG_SKIP  = 8,
    parameter int SKIP_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid_i,
    input  logic [PORT_W-1:0]    lk_port_i,
    input  logic                 lk_tagged_i,
    input  logic                 lk_ext_i,
    input  logic [NUM_PORTS-1:0] hit_i,
    input  logic [NUM_PORTS-1:0] en_i,
    output logic                 res_valid_o,
    output logic                 res_hit_o,
    output logic                 res_drop_o,
    output logic [SKIP_W-1:0]    res_skip_o
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              drop;
        logic [SKIP_W-1:0] skip;
    } res_t;

    res_t st_d, st_q;
    logic port_hit;
    logic port_en;

    always_comb begin
        port_hit = 1'b0;
        port_en  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (lk_port_i == PORT_W'(p)) begin
                port_hit = hit_i[p];
                port_en  = en_i[p];
            end
        end

        st_d       = '0;
        st_d.valid = lk_valid_i;
        if (lk_valid_i && lk_tagged_i) begin
            st_d.skip = lk_ext_i ? SKIP_W'(LONG_SKIP) : SKIP_W'(SHORT_SKIP);
            st_d.hit  = port_hit;
            st_d.drop = port_en && !port_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.valid;
    assign res_hit_o   = st_q.hit;
    assign res_drop_o  = st_q.drop;
    assign res_skip_o  = st_q.skip;
endmodule

// File: rtl/vlan_vid_filter.sv
module vlan_vid_filter #(
    parameter int NUM_PORTS      = 3,
    parameter int SLOTS_PER_PORT = 10,
    parameter int VID_W          = 12,
    parameter int SHORT_SKIP     = 4,
    parameter int LONG_SKIP      = 8,
    parameter int PORT_W         = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    parameter int SKIP_W         = $clog2(LONG_SKIP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PORT_W-1:0] cmd_port,
    input  logic [VID_W-1:0]  cmd_vid,
    output logic              cmd_done,
    output logic              cmd_err,
    input  logic              lk_valid,
    input  logic [PORT_W-1:0] lk_port,
    input  logic              lk_tagged,
    input  logic [VID_W-1:0]  lk_vid,
    input  logic              lk_ext,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_drop,
    output logic [SKIP_W-1:0] res_skip
);
    logic [NUM_PORTS-1:0] add_v, rem_v, clr_v, en_v;
    logic [NUM_PORTS-1:0] present_v, full_v, hit_v;

    vpf_ctrl #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_valid),
        .cmd_op_i   (cmd_op),
        .cmd_port_i (cmd_port),
        .present_i  (present_v),
        .full_i     (full_v),
        .add_o      (add_v),
        .rem_o      (rem_v),
        .clr_o      (clr_v),
        .en_o       (en_v),
        .done_o     (cmd_done),
        .err_o      (cmd_err)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        vpf_port_table #(
            .SLOTS(SLOTS_PER_PORT),
            .VID_W(VID_W)
        ) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .add_i    (add_v[p]),
            .rem_i    (rem_v[p]),
            .clr_i    (clr_v[p]),
            .cmd_vid_i(cmd_vid),
            .lk_vid_i (lk_vid),
            .present_o(present_v[p]),
            .full_o   (full_v[p]),
            .lk_hit_o (hit_v[p])
        );
    end

    vpf_lookup #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .SHORT_SKIP(SHORT_SKIP),
        .LONG_SKIP (LONG_SKIP),
        .SKIP_W    (SKIP_W)
    ) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid_i (lk_valid),
        .lk_port_i  (lk_port),
        .lk_tagged_i(lk_tagged),
        .lk_ext_i   (lk_ext),
        .hit_i      (hit_v),
        .en_i       (en_v),
        .res_valid_o(res_valid),
        .res_hit_o  (res_hit),
        .res_drop_o (res_drop),
        .res_skip_o (res_skip)
    );
endmodule

// File: rtl/vpf_checker.sv
module vpf_checker #(
    parameter int NUM_PORTS  = 3,
    parameter int SHORT_SKIP = 4,
    parameter int LONG_SKIP  = 8,
    parameter int PORT_W     = 2,
    parameter int SKIP_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_done,
    input logic              cmd_err,
    input logic              lk_valid,
    input logic [PORT_W-1:0] lk_port,
    input logic              lk_tagged,
    input logic              lk_ext,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_drop,
    input logic [SKIP_W-1:0] res_skip
);
    a_r12_res_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    a_r12_no_spurious_res: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    a_r12_cmd_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_done);
    a_r12_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_done);
    a_r3_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);
    a_r6_drop_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (!res_hit && res_skip != '0));
    a_r7_long_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_tagged && lk_ext) |=> (res_skip == SKIP_W'(LONG_SKIP)));
    a_r7_short_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_tagged && !lk_ext) |=> (res_skip == SKIP_W'(SHORT_SKIP)));
    a_r7_untagged_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_tagged) |=> (res_skip == '0 && !res_drop && !res_hit));
    a_r13_bad_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && int'(lk_port) >= NUM_PORTS) |=> (!res_hit && !res_drop));
endmodule

bind vlan_vid_filter vpf_checker #(
    .NUM_PORTS (NUM_PORTS),
    .SHORT_SKIP(SHORT_SKIP),
    .LONG_SKIP (LONG_SKIP),
    .PORT_W    (PORT_W),
    .SKIP_W    (SKIP_W)
) u_vpf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_done (cmd_done),
    .cmd_err  (cmd_err),
    .lk_valid (lk_valid),
    .lk_port  (lk_port),
    .lk_tagged(lk_tagged),
    .lk_ext   (lk_ext),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_drop (res_drop),
    .res_skip (res_skip)
);

// File: tb/vlan_vid_filter_bench.sv
`timescale 1ns/1ps
module vlan_vid_filter_bench;
    localparam int NP    = 3;
    localparam int SLOTS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [1:0] cmd_port = 2'b00;
    logic [11:0] cmd_vid = '0;
    logic       cmd_done, cmd_err;
    logic       lk_valid = 1'b0;
    logic [1:0] lk_port = 2'b00;
    logic       lk_tagged = 1'b0;
    logic [11:0] lk_vid = '0;
    logic       lk_ext = 1'b0;
    logic       res_valid, res_hit, res_drop;
    logic [3:0] res_skip;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit allow [NP][4096];
    int cnt [NP];
    bit en [NP];

    always #2 clk = ~clk;

    vlan_vid_filter u_vlan_vid_filter (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_vid(cmd_vid),
        .cmd_done(cmd_done), .cmd_err(cmd_err),
        .lk_valid(lk_valid), .lk_port(lk_port), .lk_tagged(lk_tagged),
        .lk_vid(lk_vid), .lk_ext(lk_ext),
        .res_valid(res_valid), .res_hit(res_hit), .res_drop(res_drop), .res_skip(res_skip)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at a falling edge, predict from the model, compare at the next falling edge
    task automatic step(string tag, bit cv, int op, int cp, int cvid,
                        bit lv, int lp, bit lt, int lvid, bit le);
        int e_hit, e_drop, e_skip, e_err;
        cmd_valid = cv; cmd_op = 2'(op); cmd_port = 2'(cp); cmd_vid = 12'(cvid);
        lk_valid = lv; lk_port = 2'(lp); lk_tagged = lt; lk_vid = 12'(lvid); lk_ext = le;
        e_hit = 0; e_drop = 0; e_skip = 0;
        if (lv && lt) begin
            e_skip = le ? 8 : 4;
            if (lp < NP) begin
                e_hit  = allow[lp][lvid] ? 1 : 0;
                e_drop = (en[lp] && !allow[lp][lvid]) ? 1 : 0;
            end
        end
        e_err = 0;
        if (cv) begin
            if (cp >= NP) e_err = 1;
            else case (op)
                0: if (!allow[cp][cvid]) begin
                       if (cnt[cp] == SLOTS) e_err = 1;
                       else begin allow[cp][cvid] = 1'b1; cnt[cp]++; end
                   end
                1: if (allow[cp][cvid]) begin allow[cp][cvid] = 1'b0; cnt[cp]--; end
                2: en[cp] = 1'b1;
                default: begin
                    en[cp] = 1'b0; cnt[cp] = 0;
                    for (int v = 0; v < 4096; v++) allow[cp][v] = 1'b0;
                end
            endcase
        end
        @(negedge clk);
        check(tag, "cmd_done", int'(cmd_done), int'(cv));
        if (cv) check(tag, "cmd_err", int'(cmd_err), e_err);
        check(tag, "res_valid", int'(res_valid), int'(lv));
        if (lv) begin
            check(tag, "res_hit", int'(res_hit), e_hit);
            check(tag, "res_drop", int'(res_drop), e_drop);
            check(tag, "res_skip", int'(res_skip), e_skip);
        end
    endtask

    task automatic cmd(string tag, int op, int cp, int cvid);
        step(tag, 1, op, cp, cvid, 0, 0, 0, 0, 0);
    endtask

    task automatic look(string tag, int lp, bit lt, int lvid, bit le);
        step(tag, 0, 0, 0, 0, 1, lp, lt, lvid, le);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog R12 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin cnt[p] = 0; en[p] = 1'b0; end
        repeat (3) @(negedge clk);
        // reset state
        check("R8", "reset res_valid", int'(res_valid), 0);
        check("R8", "reset cmd_done", int'(cmd_done), 0);
        check("R8", "reset cmd_err", int'(cmd_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        look("R8", 0, 1, 12'h005, 0);                 // not filtering: no drop
        look("R7", 0, 0, 12'h005, 1);                 // untagged: all zero
        for (int k = 0; k < SLOTS; k++) cmd("R1", 0, 0, 16 + k);
        look("R5", 0, 1, 20, 0);
        cmd("R3", 0, 0, 99);                          // full: rejected
        look("R3", 0, 1, 99, 0);
        cmd("R2", 0, 0, 18);                          // existing: accepted
        cmd("R6", 2, 0, 0);                           // enable port 0
        look("R6", 0, 1, 99, 0);
        look("R7", 0, 1, 99, 1);
        look("R4", 0, 1, 12'h800 + 16, 0);            // top bit differs
        look("R11", 1, 1, 20, 0);
        cmd("R10", 1, 0, 17);
        look("R10", 0, 1, 17, 0);
        cmd("R10", 1, 0, 500);                        // absent: no effect
        // add and lookup in the same cycle: old table used
        step("R12", 1, 0, 0, 777, 1, 0, 1, 777, 0);
        look("R12", 0, 1, 777, 0);
        cmd("R9", 3, 0, 0);                           // disable clears slots
        look("R9", 0, 1, 20, 0);
        cmd("R9", 2, 0, 0);
        look("R9", 0, 1, 20, 1);
        cmd("R13", 0, 3, 20);
        look("R13", 3, 1, 20, 0);

        for (int n = 0; n < 4000; n++) begin
            int r, op, cp, lp, lvid;
            r = int'($urandom % 100);
            op = (r < 55) ? 0 : (r < 80) ? 1 : (r < 97) ? 2 : 3;
            cp = int'($urandom % 4);
            lp = int'($urandom % 4);
            lvid = ($urandom % 8 == 0) ? int'($urandom % 4096) : int'(($urandom % 14) * 293 % 4096);
            step("RND", ($urandom % 3) != 0, op, cp, int'(($urandom % 14) * 293 % 4096),
                 ($urandom % 4) != 0, lp, ($urandom % 5) != 0, lvid, $urandom % 2 == 0);
        end

        cmd_valid = 1'b0; lk_valid = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule